// File: doc/BRIEF.md
# Equalizer Configuration Serial Slave

A host microcontroller uses this block to set up an equalizer over a four-wire serial link. The wires are a transfer enable, a 2-bit transfer kind, a bit clock and a data line. The data line is split into an input, an output and an output enable, so it can be joined to a pad. All four link inputs are retimed into the system clock domain before the block detects any edge on them. Each transfer moves exactly one byte, least significant bit first.

The host picks one of four transfer kinds for each byte:

- a mode byte, which sets the operating mode and the readback selection;
- an address byte, which picks a channel and a tap;
- a coefficient byte, written into the selected slot;
- a read, which returns either the selected coefficient or a packed tape-speed status word.

The store holds nine channels of twelve signed 8-bit taps. A separate lookup port lets the downstream filter fetch any coefficient.

Top module: `eqcfg_serial_slave`

## Requirements
- R1: After reset the operating mode is 11 (off), the readback selection is 01 (coefficient), the selected channel and tap are 0, the data output enable is low, and every coefficient is zero.
- R2: The transfer kind latched when the enable rises selects the action: 00 writes a coefficient, 01 reads to the host, 10 writes an address, 11 writes the mode byte. A mode byte sets the operating mode from bits 1:0 and the readback selection from bits 3:2.
- R3: An address byte sets the channel from bits 7:4 and the tap from bits 3:0. Channels 0 to 7 are data channels and channel 8 is the auxiliary channel.
- R4: An address byte with a channel above 8 or a tap above 11 leaves the selected channel and tap unchanged.
- R5: A coefficient byte overwrites only the entry at the selected channel and tap. The lookup port returns that stored value.
- R6: A coefficient write to channel 8, tap 0 stores zero, whatever the byte.
- R7: A read returns the coefficient at the selected channel and tap when the readback selection is not 11. Bits come out least significant first, and each bit is held on the output until the next rising edge of the bit clock.
- R8: When the readback selection is 11, a read returns a byte built from the speed inputs at the start of the transfer: the invalid flag in bit 7, the 5-bit count in bits 6:2, and the range in bits 1:0.
- R9: The data output enable is high only while a read transfer is in progress. It is low during writes and when the link is idle.
- R10: A transfer that ends with fewer than 8 bit-clock rising edges changes no state. Bit-clock edges after the eighth are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sel_in | input | 1 | Transfer enable from host |
| kind_in | input | 2 | Transfer kind from host |
| sclk_in | input | 1 | Bit clock from host |
| sdata_in | input | 1 | Serial data from host |
| sdata_out | output | 1 | Serial data to host |
| sdata_oe | output | 1 | Drive enable for the data pad |
| speed_bad | input | 1 | Speed measurement invalid flag |
| speed_count | input | 5 | Speed count |
| speed_range | input | 2 | Speed range |
| op_mode | output | 2 | Operating mode |
| xchg_type | output | 2 | Readback selection |
| cur_chan | output | 4 | Selected channel |
| cur_tap | output | 4 | Selected tap |
| coef_chan | input | 4 | Lookup channel |
| coef_tap | input | 4 | Lookup tap |
| coef_val | output | 8 | Looked-up coefficient |

## Verification
Random sequences of address, coefficient, mode and read transfers are checked against a model of the store. Some of the random addresses fall outside the valid range, which separates addresses that are accepted from addresses that are ignored. Random speed words are read with the readback selection at 11, which tests the bit packing and separates that path from the coefficient path. Directed cases cover the auxiliary tap 0, a short transfer, and extra bit-clock edges, which tell the commit and discard rules apart.

// File: rtl/eqcfg_serial_slave.sv
module eqcfg_serial_slave #(
  parameter int CH   = 9,
  parameter int TAPS = 12,
  parameter int W    = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_in,
  input  logic [1:0]   kind_in,
  input  logic         sclk_in,
  input  logic         sdata_in,
  output logic         sdata_out,
  output logic         sdata_oe,
  input  logic         speed_bad,
  input  logic [4:0]   speed_count,
  input  logic [1:0]   speed_range,
  output logic [1:0]   op_mode,
  output logic [1:0]   xchg_type,
  output logic [3:0]   cur_chan,
  output logic [3:0]   cur_tap,
  input  logic [3:0]   coef_chan,
  input  logic [3:0]   coef_tap,
  output logic [W-1:0] coef_val
);
  localparam int DEPTH = CH * TAPS;
  localparam int IW    = $clog2(DEPTH);
  localparam int AUX   = CH - 1;

  logic [4:0]   s1, s2;
  logic         sel_d, sclk_d, rd_act;
  logic [1:0]   kind_q;
  logic [3:0]   cnt;
  logic [W-1:0] sh, rd_sh;
  logic [W-1:0] mem [DEPTH];

  wire sel_s  = s2[4];
  wire [1:0] kind_s = s2[3:2];
  wire sclk_s = s2[1];
  wire dat_s  = s2[0];

  wire [IW-1:0] widx = IW'(int'(cur_chan) * TAPS + int'(cur_tap));
  wire          rok  = (int'(coef_chan) < CH) && (int'(coef_tap) < TAPS);
  wire [IW-1:0] ridx = rok ? IW'(int'(coef_chan) * TAPS + int'(coef_tap)) : '0;

  assign coef_val  = rok ? mem[ridx] : '0;
  assign sdata_oe  = sel_s & rd_act;
  assign sdata_out = rd_act ? rd_sh[0] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0;
      sel_d <= 1'b0; sclk_d <= 1'b0; rd_act <= 1'b0;
      kind_q <= '0; cnt <= '0; sh <= '0; rd_sh <= '0;
      op_mode <= 2'b11; xchg_type <= 2'b01;
      cur_chan <= '0; cur_tap <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      s1 <= {sel_in, kind_in, sclk_in, sdata_in};
      s2 <= s1;
      sel_d  <= sel_s;
      sclk_d <= sclk_s;
      if (sel_s && !sel_d) begin
        kind_q <= kind_s;
        cnt    <= '0;
        rd_act <= (kind_s == 2'b01);
        rd_sh  <= (xchg_type == 2'b11) ? {speed_bad, speed_count, speed_range} : mem[widx];
      end else if (sel_s && sclk_s && !sclk_d && cnt < 4'(W)) begin
        cnt   <= cnt + 4'd1;
        sh    <= {dat_s, sh[W-1:1]};
        rd_sh <= {1'b0, rd_sh[W-1:1]};
      end else if (!sel_s && sel_d) begin
        rd_act <= 1'b0;
        if (cnt == 4'(W)) begin
          case (kind_q)
            2'b11: begin
              op_mode   <= sh[1:0];
              xchg_type <= sh[3:2];
            end
            2'b10:
              if (int'(sh[7:4]) < CH && int'(sh[3:0]) < TAPS) begin
                cur_chan <= sh[7:4];
                cur_tap  <= sh[3:0];
              end
            2'b00:
              mem[widx] <= (int'(cur_chan) == AUX && cur_tap == 4'd0) ? '0 : sh;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module eqcfg_serial_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_in,
  input logic       sdata_oe,
  input logic [1:0] op_mode,
  input logic [3:0] cur_chan,
  input logic [3:0] cur_tap,
  input logic [3:0] coef_chan,
  input logic [3:0] coef_tap,
  input logic [7:0] coef_val
);
  // R9
  oe_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdata_oe |-> $past(sel_in, 2));
  // R2
  mode_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(op_mode) |-> !$past(sel_in, 3));
  // R4
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_chan <= 4'd8 && cur_tap <= 4'd11);
  // R6
  aux_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_chan == 4'd8 && coef_tap == 4'd0) |-> coef_val == 8'd0);
endmodule

bind eqcfg_serial_slave eqcfg_serial_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_in(sel_in), .sdata_oe(sdata_oe),
  .op_mode(op_mode), .cur_chan(cur_chan), .cur_tap(cur_tap),
  .coef_chan(coef_chan), .coef_tap(coef_tap), .coef_val(coef_val));

// File: tb/eqcfg_serial_slave_bench.sv
module eqcfg_serial_slave_bench;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic sel_in = 0, sclk_in = 0, sdata_in = 0;
  logic [1:0] kind_in = 0;
  logic sdata_out, sdata_oe, speed_bad = 0;
  logic [4:0] speed_count = 0;
  logic [1:0] speed_range = 0, op_mode, xchg_type;
  logic [3:0] cur_chan, cur_tap, coef_chan = 0, coef_tap = 0;
  logic [7:0] coef_val;

  eqcfg_serial_slave u_eqcfg_serial_slave (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_mem [108];
  logic [1:0] m_mode = 2'b11, m_xt = 2'b01;
  logic [3:0] m_ch = 0, m_tp = 0;

  function automatic int idx(input logic [3:0] c, input logic [3:0] t);
    return int'(c) * 12 + int'(t);
  endfunction
  function automatic logic [7:0] spd(input logic b, input logic [4:0] c, input logic [1:0] r);
    return {b, c, r};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [1:0] k, input logic [7:0] b, input int nb, output logic [7:0] got);
    got = 0;
    kind_in = k; cyc(4);
    sel_in = 1; cyc(6);
    for (int i = 0; i < nb; i++) begin
      sclk_in = 0; sdata_in = b[i % 8]; cyc(8);
      if (i < 8) got[i] = sdata_out;
      if (i == 0) chk("R9", sdata_oe, k == 2'b01);
      sclk_in = 1; cyc(8);
    end
    sclk_in = 0; cyc(4);
    sel_in = 0; cyc(8);
    chk("R9", sdata_oe, 0);
  endtask

  task automatic wr(input logic [1:0] k, input logic [7:0] b);
    logic [7:0] g;
    xfer(k, b, 8, g);
    case (k)
      2'b11: begin m_mode = b[1:0]; m_xt = b[3:2]; end
      2'b10: if (b[7:4] <= 8 && b[3:0] <= 11) begin m_ch = b[7:4]; m_tp = b[3:0]; end
      2'b00: m_mem[idx(m_ch, m_tp)] = (m_ch == 8 && m_tp == 0) ? 8'h00 : b;
      default: ;
    endcase
  endtask

  task automatic rd_check();
    logic [7:0] g, e;
    e = (m_xt == 2'b11) ? spd(speed_bad, speed_count, speed_range) : m_mem[idx(m_ch, m_tp)];
    xfer(2'b01, 8'h00, 8, g);
    if (m_xt == 2'b11) chk("R8", g, e); else chk("R7", g, e);
  endtask

  task automatic state_check(input string req);
    chk(req, op_mode, m_mode);
    chk(req, xchg_type, m_xt);
    chk(req, cur_chan, m_ch);
    chk(req, cur_tap, m_tp);
  endtask

  task automatic look_check(input logic [3:0] c, input logic [3:0] t);
    coef_chan = c; coef_tap = t; cyc(1);
    chk("R5", coef_val, m_mem[idx(c, t)]);
  endtask

  initial begin
    logic [7:0] g;
    void'($urandom(32'd20240607));
    for (int i = 0; i < 108; i++) m_mem[i] = 0;
    cyc(5); rst_n = 1; cyc(3);
    // R1 reset state
    state_check("R1");
    chk("R1", sdata_oe, 0);
    for (int c = 0; c < 9; c++) begin
      coef_chan = 4'(c); coef_tap = 4'(c + 2); cyc(1);
      chk("R1", coef_val, 0);
    end

    // R2 mode byte
    wr(2'b11, 8'hF4); state_check("R2");
    wr(2'b11, 8'h06); state_check("R2");
    // R3 address
    wr(2'b10, 8'h35); state_check("R3");
    // R5 coefficient write
    wr(2'b00, 8'hA7); look_check(4'd3, 4'd5); look_check(4'd3, 4'd4);
    // R7 read, selection 01 then 00
    wr(2'b11, 8'h04); rd_check();
    wr(2'b11, 8'h00); rd_check();
    // R4 out-of-range address
    wr(2'b10, 8'h92); state_check("R4");
    wr(2'b10, 8'h2C); state_check("R4");
    rd_check();
    // R6 aux tap 0
    wr(2'b10, 8'h80); wr(2'b00, 8'hFF);
    look_check(4'd8, 4'd0); chk("R6", coef_val, 0);
    wr(2'b11, 8'h04); rd_check();
    wr(2'b10, 8'h81); wr(2'b00, 8'h81); look_check(4'd8, 4'd1);
    // R10 short transfer discarded
    xfer(2'b11, 8'h0B, 5, g); state_check("R10");
    xfer(2'b10, 8'h11, 7, g); state_check("R10");
    // R10 extra edges ignored: first 8 bits are committed
    xfer(2'b10, 8'h47, 11, g); m_ch = 4; m_tp = 7; state_check("R10");
    // R8 speed word
    wr(2'b11, 8'h0C);
    speed_bad = 1; speed_count = 5'h15; speed_range = 2'b10; rd_check();
    speed_bad = 0; speed_count = 5'h0A; speed_range = 2'b01; rd_check();

    // random mix
    for (int it = 0; it < 150; it++) begin
      int op;
      op = $urandom % 5;
      case (op)
        0: wr(2'b10, {4'($urandom % 11), 4'($urandom % 14)});
        1: wr(2'b00, 8'($urandom));
        2: rd_check();
        3: begin
          logic [1:0] xt;
          xt = ($urandom % 3 == 0) ? 2'b11 : 2'($urandom % 2);
          wr(2'b11, {4'($urandom), xt, 2'($urandom)});
          speed_bad = 1'($urandom); speed_count = 5'($urandom); speed_range = 2'($urandom);
          rd_check();
        end
        default: look_check(4'($urandom % 9), 4'($urandom % 12));
      endcase
      if (op == 0) state_check("R3");
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule